// File: doc/BRIEF.md
# Dual-Port Circular Address Generator

This block keeps four independent addressing contexts for a data path that reads two operands per cycle. Each context holds a current index, a step value, a buffer length and a buffer start, and every one of them is 32 bits wide. Two request ports each name a context. In the same cycle each port sees that context's current index as its memory address.

When a port asks for a post-modify, the index of its context advances by a signed step. The step comes either from the context's own step register or from an immediate supplied with the request. When the length is nonzero the new index is folded back into the window that starts at the base and spans the length bytes, so a stream of accesses circles through the buffer with no software check. A length of zero gives plain linear stepping. A single write port loads any field of any context.

Top module: `cag_dual_agu`

## Requirements
- R1: After reset every field of every context is zero, so both address outputs read 0 for any selected context.
- R2: Each port's address output equals the current index of the context it selects, in the same cycle. Both ports are served at once, and this also holds when they select the same context.
- R3: With length 0, a post-modify sets the index to index + step modulo 2^32.
- R4: With length L nonzero, when index + step is greater than or equal to base + L, the new index is index + step − L. The comparison is made without 32-bit overflow.
- R5: With length L nonzero, when index + step is below base, the new index is index + step + L.
- R6: The step is a signed two's-complement value. Modify-source 1 takes the request's immediate, and modify-source 0 takes the context's step register.
- R7: When a port's post-modify enable is low, the index of its context is left unchanged.
- R8: When both ports post-modify the same context in one cycle, port A's result is kept.
- R9: The write field code is 0 index, 1 step, 2 length, 3 base. A write is visible from the next cycle. An index write beats a post-modify of the same context in the same cycle.
- R10: A post-modify in the same cycle as a write to that context's step, length or base uses the values from before the write.
- R11: Post-modifies on two different contexts in the same cycle both take effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_set_i | input | 2 | Context written |
| wr_fld_i | input | 2 | Field written (0 index, 1 step, 2 length, 3 base) |
| wr_data_i | input | 32 | Write data |
| a_set_i | input | 2 | Port A context select |
| a_imm_sel_i | input | 1 | Port A step source: 1 immediate, 0 step register |
| a_imm_i | input | 32 | Port A immediate step |
| a_upd_i | input | 1 | Port A post-modify enable |
| a_addr_o | output | 32 | Port A address |
| b_set_i | input | 2 | Port B context select |
| b_imm_sel_i | input | 1 | Port B step source: 1 immediate, 0 step register |
| b_imm_i | input | 32 | Port B immediate step |
| b_upd_i | input | 1 | Port B post-modify enable |
| b_addr_o | output | 32 | Port B address |

## Verification
Three collisions can land in one cycle. Both ports can post-modify the same context, a write can hit an index that a port is also updating, and a write can change the length or base under a port's update. The bench provokes each one by driving the write strobe and both update enables in the same cycle. It then reads the resulting index back through an address output on the following cycle. The outcome is judged against R8, R9 and R10: port A's value is kept, the written value is kept, and the wrap is computed from the length before the write, which differs from the result the new length would give.

// File: rtl/cag_pkg.sv
package cag_pkg;
    localparam int unsigned AW     = 32;
    localparam int unsigned NSETS  = 4;
    localparam int unsigned SW     = $clog2(NSETS);
    localparam int unsigned NPORTS = 2;

    typedef enum logic [1:0] {
        FLD_IDX  = 2'd0,
        FLD_MOD  = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_BASE = 2'd3
    } fld_e;

    typedef struct packed {
        logic [AW-1:0] idx;
        logic [AW-1:0] mod;
        logic [AW-1:0] len;
        logic [AW-1:0] base;
    } ctx_t;

    typedef struct packed {
        ctx_t [NSETS-1:0] sets;
    } bank_t;
endpackage

// File: rtl/cag_step.sv
module cag_step
    import cag_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  ctx_t          cur_i,
    input  logic [AW-1:0] step_i,
    output logic [AW-1:0] nxt_o
);
    localparam int unsigned XW = AW + 2;

    logic signed [XW-1:0] sum_x, lo_x, hi_x, len_x, idx_x, fold_x, nxt_x;
    logic        [AW-1:0] mag;
    logic                 in_buf;

    always_comb begin
        len_x  = $signed({2'b00, cur_i.len});
        lo_x   = $signed({2'b00, cur_i.base});
        idx_x  = $signed({2'b00, cur_i.idx});
        hi_x   = lo_x + len_x;
        sum_x  = idx_x + $signed({{2{step_i[AW-1]}}, step_i});
        fold_x = sum_x;
        if (cur_i.len != '0) begin
            if (sum_x >= hi_x) begin
                fold_x = sum_x - len_x;
            end else if (sum_x < lo_x) begin
                fold_x = sum_x + len_x;
            end
        end
        nxt_o = fold_x[AW-1:0];
    end

    // Checker helpers: a legal in-window access must stay inside the window.
    always_comb begin
        mag    = step_i[AW-1] ? (~step_i + 1'b1) : step_i;
        in_buf = (cur_i.len != '0) && (idx_x >= lo_x) && (idx_x < hi_x) && (mag < cur_i.len);
        nxt_x  = $signed({2'b00, nxt_o});
    end

    assert_stays_in_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_buf |-> ((nxt_x >= lo_x) && (nxt_x < hi_x)))
        else $error("index left its circular window (R4/R5)");
endmodule

// File: rtl/cag_bank.sv
module cag_bank
    import cag_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [SW-1:0]    wr_set_i,
    input  logic [1:0]       wr_fld_i,
    input  logic [AW-1:0]    wr_data_i,
    input  logic             upd0_i,
    input  logic [SW-1:0]    set0_i,
    input  logic [AW-1:0]    nxt0_i,
    input  logic             upd1_i,
    input  logic [SW-1:0]    set1_i,
    input  logic [AW-1:0]    nxt1_i,
    output ctx_t [NSETS-1:0] sets_o
);
    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // port 1 first so port 0 overrides on a shared context
        if (upd1_i) st_d.sets[set1_i].idx = nxt1_i;
        if (upd0_i) st_d.sets[set0_i].idx = nxt0_i;
        // explicit writes override any post-modify
        if (wr_en_i) begin
            unique case (fld_e'(wr_fld_i))
                FLD_IDX:  st_d.sets[wr_set_i].idx  = wr_data_i;
                FLD_MOD:  st_d.sets[wr_set_i].mod  = wr_data_i;
                FLD_LEN:  st_d.sets[wr_set_i].len  = wr_data_i;
                FLD_BASE: st_d.sets[wr_set_i].base = wr_data_i;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sets_o = st_q.sets;

    assert_port0_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd0_i && upd1_i && set0_i == set1_i &&
         !(wr_en_i && wr_fld_i == FLD_IDX && wr_set_i == set0_i))
        |=> sets_o[$past(set0_i)].idx == $past(nxt0_i))
        else $error("port A did not win a shared update (R8)");

    assert_index_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_fld_i == FLD_IDX)
        |=> sets_o[$past(wr_set_i)].idx == $past(wr_data_i))
        else $error("index write lost (R9)");

    for (genvar k = 0; k < NSETS; k++) begin : g_chk
        assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !((upd0_i && set0_i == SW'(k)) || (upd1_i && set1_i == SW'(k)) ||
              (wr_en_i && wr_set_i == SW'(k) && wr_fld_i == FLD_IDX))
            |=> $stable(sets_o[k].idx))
            else $error("index changed without cause (R7)");

        assert_len_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(wr_en_i && wr_set_i == SW'(k) && wr_fld_i == FLD_LEN)
            |=> $stable(sets_o[k].len))
            else $error("length changed without a write (R10)");
    end
endmodule

// File: rtl/cag_dual_agu.sv
module cag_dual_agu
    import cag_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [1:0]    wr_set_i,
    input  logic [1:0]    wr_fld_i,
    input  logic [31:0]   wr_data_i,
    input  logic [1:0]    a_set_i,
    input  logic          a_imm_sel_i,
    input  logic [31:0]   a_imm_i,
    input  logic          a_upd_i,
    output logic [31:0]   a_addr_o,
    input  logic [1:0]    b_set_i,
    input  logic          b_imm_sel_i,
    input  logic [31:0]   b_imm_i,
    input  logic          b_upd_i,
    output logic [31:0]   b_addr_o
);
    ctx_t [NSETS-1:0]  sets;
    logic [SW-1:0]     p_set  [NPORTS];
    logic              p_isel [NPORTS];
    logic [AW-1:0]     p_imm  [NPORTS];
    logic              p_upd  [NPORTS];
    logic [AW-1:0]     p_addr [NPORTS];
    logic [AW-1:0]     p_nxt  [NPORTS];

    always_comb begin
        p_set[0]  = a_set_i;     p_set[1]  = b_set_i;
        p_isel[0] = a_imm_sel_i; p_isel[1] = b_imm_sel_i;
        p_imm[0]  = a_imm_i;     p_imm[1]  = b_imm_i;
        p_upd[0]  = a_upd_i;     p_upd[1]  = b_upd_i;
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        ctx_t          cur;
        logic [AW-1:0] step;

        always_comb begin
            cur       = sets[p_set[p]];
            step      = p_isel[p] ? p_imm[p] : cur.mod;
            p_addr[p] = cur.idx;
        end

        cag_step u_step (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cur_i  (cur),
            .step_i (step),
            .nxt_o  (p_nxt[p])
        );
    end

    cag_bank u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_set_i  (wr_set_i),
        .wr_fld_i  (wr_fld_i),
        .wr_data_i (wr_data_i),
        .upd0_i    (p_upd[0]),
        .set0_i    (p_set[0]),
        .nxt0_i    (p_nxt[0]),
        .upd1_i    (p_upd[1]),
        .set1_i    (p_set[1]),
        .nxt1_i    (p_nxt[1]),
        .sets_o    (sets)
    );

    assign a_addr_o = p_addr[0];
    assign b_addr_o = p_addr[1];
endmodule

// File: tb/tb_cag_dual_agu.sv
module tb_cag_dual_agu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_set = '0, wr_fld = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  a_set = '0, b_set = '0;
    logic        a_isel = 1'b0, b_isel = 1'b0, a_upd = 1'b0, b_upd = 1'b0;
    logic [31:0] a_imm = '0, b_imm = '0;
    logic [31:0] a_addr, b_addr;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cag_dual_agu dut (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_set_i(wr_set), .wr_fld_i(wr_fld), .wr_data_i(wr_data),
        .a_set_i(a_set), .a_imm_sel_i(a_isel), .a_imm_i(a_imm), .a_upd_i(a_upd), .a_addr_o(a_addr),
        .b_set_i(b_set), .b_imm_sel_i(b_isel), .b_imm_i(b_imm), .b_upd_i(b_upd), .b_addr_o(b_addr)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic [31:0] i, logic [31:0] m, logic [31:0] l, logic [31:0] b);
        longint s, lo, hi;
        s  = longint'(i) + longint'($signed(m));
        lo = longint'(b);
        hi = longint'(b) + longint'(l);
        if (l != 0) begin
            if (s >= hi) s = s - longint'(l);
            else if (s < lo) s = s + longint'(l);
        end
        return s[31:0];
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic wr(logic [1:0] s, logic [1:0] f, logic [31:0] d);
        wr_en = 1'b1; wr_set = s; wr_fld = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(logic [1:0] s, logic [31:0] b, logic [31:0] l, int span);
        logic [31:0] e;
        wr(s, 2'd3, b);
        wr(s, 2'd2, l);
        for (int o = 0; o < int'(l); o++) begin
            for (int m = -span; m <= span; m++) begin
                wr(s, 2'd0, b + 32'(o));
                e = model(b + 32'(o), 32'(m), l, b);
                if (m[0]) begin
                    b_set = s; b_isel = 1'b1; b_imm = 32'(m); b_upd = 1'b1;
                    #1 check("R2", b_addr, b + 32'(o));
                    @(negedge clk); b_upd = 1'b0;
                    #1 check((32'(o) + 32'(m) >= l) ? "R4" : ((o + m < 0) ? "R5" : "R6"), b_addr, e);
                end else begin
                    a_set = s; a_isel = 1'b1; a_imm = 32'(m); a_upd = 1'b1;
                    #1 check("R2", a_addr, b + 32'(o));
                    @(negedge clk); a_upd = 1'b0;
                    #1 check((32'(o) + 32'(m) >= l) ? "R4" : ((o + m < 0) ? "R5" : "R6"), a_addr, e);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            a_set = 2'(s); b_set = 2'(3 - s);
            #1 check("R1", a_addr, 32'h0);
            check("R1", b_addr, 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // circular sweeps: mid-range window and a window ending at the top of the space
        sweep(2'd2, 32'd100, 32'd10, 9);
        sweep(2'd3, 32'hFFFF_FFF0, 32'd16, 15);

        // R3 linear mode, modulo 2^32
        wr(2'd0, 2'd0, 32'hFFFF_FFFE);
        a_set = 2'd0; a_isel = 1'b1; a_imm = 32'd5; a_upd = 1'b1;
        @(negedge clk); a_upd = 1'b0;
        #1 check("R3", a_addr, 32'h0000_0003);
        a_imm = -32'sd7; a_upd = 1'b1;
        @(negedge clk); a_upd = 1'b0;
        #1 check("R3", a_addr, 32'hFFFF_FFFC);

        // R6 step register source on set 1 (linear)
        wr(2'd1, 2'd0, 32'd1000);
        wr(2'd1, 2'd1, -32'sd24);
        b_set = 2'd1; b_isel = 1'b0; b_imm = 32'd99; b_upd = 1'b1;
        @(negedge clk); b_upd = 1'b0;
        #1 check("R6", b_addr, 32'd976);

        // R7 request without post-modify
        a_set = 2'd1; a_isel = 1'b1; a_imm = 32'd8; a_upd = 1'b0;
        @(negedge clk);
        #1 check("R7", a_addr, 32'd976);

        // R8 both ports on set 2 (B=100,L=10): A +3, B -4 from 105
        wr(2'd2, 2'd0, 32'd105);
        a_set = 2'd2; a_imm = 32'd3; a_upd = 1'b1;
        b_set = 2'd2; b_isel = 1'b1; b_imm = -32'sd4; b_upd = 1'b1;
        #1 check("R2", b_addr, 32'd105);
        @(negedge clk); a_upd = 1'b0; b_upd = 1'b0;
        #1 check("R8", b_addr, 32'd108);

        // R11 distinct sets: A on set 2 (108+5 -> 103), B on set 1 step reg (976-24)
        a_set = 2'd2; a_imm = 32'd5; a_upd = 1'b1;
        b_set = 2'd1; b_isel = 1'b0; b_upd = 1'b1;
        @(negedge clk); a_upd = 1'b0; b_upd = 1'b0;
        #1 check("R11", a_addr, 32'd103);
        check("R11", b_addr, 32'd952);

        // R9 index write vs concurrent update on set 2
        a_set = 2'd2; a_imm = 32'd1; a_upd = 1'b1;
        wr(2'd2, 2'd0, 32'd107);
        a_upd = 1'b0;
        #1 check("R9", a_addr, 32'd107);

        // R10 length write (10 -> 20) with concurrent update: 108+5 wraps with old L -> 103
        wr(2'd2, 2'd0, 32'd108);
        a_imm = 32'd5; a_upd = 1'b1;
        wr(2'd2, 2'd2, 32'd20);
        a_upd = 1'b0;
        #1 check("R10", a_addr, 32'd103);
        wr(2'd2, 2'd0, 32'd108);
        a_upd = 1'b1;
        @(negedge clk); a_upd = 1'b0;
        #1 check("R10", a_addr, 32'd113);

        // R10 base write with concurrent update uses old base
        wr(2'd2, 2'd0, 32'd101);
        a_imm = -32'sd3; a_upd = 1'b1;
        wr(2'd2, 2'd3, 32'd50);
        a_upd = 1'b0;
        #1 check("R10", a_addr, 32'd118);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule